// File: doc/BRIEF.md
# Issue Stall Cycle Estimator

This block sits beside the issue stage of a small in-order RV32IM pipeline and reports, for each issued instruction, how many cycles beyond the first it will occupy. It draws on two sources for the figure. A one-entry record holds the destination of the most recent instruction whose result arrives late (a load or a multiply). Fixed penalties cover control transfers and the iterative divider.

An upstream decoder supplies an issue strobe with an instruction class code, the three register fields and the branch outcome. The class decides which source fields are compared against the record and which fixed penalty applies. The stall count is combinational and valid in the same cycle as the strobe. The record updates on the clock edge that ends an issue cycle and is also presented at the ports.

Top module: `issue_penalty_calc`

## Requirements
- R1: On an issue of class LOAD (4) or MUL (1) with a nonzero destination, the record becomes valid with that destination from the next cycle. An issue of any other class empties the record.
- R2: A destination of register 0 never enters the record, so a later read of register 0 never adds an interlock cycle.
- R3: For classes ALU_RR (0), MUL (1), DIV (2) and BRANCH (6), one interlock cycle is added when either rs1 or rs2 equals the valid record.
- R4: For classes ALU_IMM (3), LOAD (4), STORE (5), JALR (8) and CSR_REG (9), one interlock cycle is added only when rs1 equals the valid record. A match on rs2 alone adds nothing.
- R5: A BRANCH whose taken flag is high adds one cycle. A not-taken branch adds nothing beyond any interlock.
- R6: JAL (7) and JALR (8) always add one cycle, on top of any interlock.
- R7: DIV adds DIV_COST cycles (default 18), on top of any interlock.
- R8: Classes CSR_IMM (10), LUI (11), AUIPC (12), FENCE (13) and the unused codes 14 and 15 compare no sources and add zero cycles.
- R9: After reset the record is empty. With the strobe low the stall count is zero and the record holds its value. With the strobe high the count is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_vld | input | 1 | An instruction issues this cycle |
| issue_cls | input | 4 | Instruction class code |
| src1 | input | REG_W | First source register index |
| src2 | input | REG_W | Second source register index |
| dst | input | REG_W | Destination register index |
| br_taken | input | 1 | Branch outcome for BRANCH class |
| stall_cnt | output | CNT_W | Extra cycles for the issuing instruction |
| rec_vld | output | 1 | Late-result record holds a register |
| rec_reg | output | REG_W | Register held by the record |

## Verification
The bench builds the block with the default values: 5-bit register indices and a divide cost of 18, which makes the count 5 bits wide. With these values the largest total, a divide that also interlocks (19), is reachable, along with every class code, including the unused ones. Register 0 as a destination, sources that match on rs2 only, and idle cycles between a fill and its consumer can all be placed directly by choosing indices.

// File: rtl/issue_penalty_calc.sv
module issue_penalty_calc #(
  parameter int REG_W    = 5,
  parameter int DIV_COST = 18,
  localparam int CNT_W   = $clog2(DIV_COST + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_vld,
  input  logic [3:0]       issue_cls,
  input  logic [REG_W-1:0] src1,
  input  logic [REG_W-1:0] src2,
  input  logic [REG_W-1:0] dst,
  input  logic             br_taken,
  output logic [CNT_W-1:0] stall_cnt,
  output logic             rec_vld,
  output logic [REG_W-1:0] rec_reg
);

  localparam logic [3:0] C_ALU_RR  = 4'd0;
  localparam logic [3:0] C_MUL     = 4'd1;
  localparam logic [3:0] C_DIV     = 4'd2;
  localparam logic [3:0] C_ALU_IMM = 4'd3;
  localparam logic [3:0] C_LOAD    = 4'd4;
  localparam logic [3:0] C_STORE   = 4'd5;
  localparam logic [3:0] C_BRANCH  = 4'd6;
  localparam logic [3:0] C_JAL     = 4'd7;
  localparam logic [3:0] C_JALR    = 4'd8;
  localparam logic [3:0] C_CSR_REG = 4'd9;

  logic use1, use2;
  logic [CNT_W-1:0] fixed_cost;

  always_comb begin
    use1 = 1'b0;
    use2 = 1'b0;
    fixed_cost = '0;
    case (issue_cls)
      C_ALU_RR, C_MUL: begin use1 = 1'b1; use2 = 1'b1; end
      C_DIV:     begin use1 = 1'b1; use2 = 1'b1; fixed_cost = CNT_W'(DIV_COST); end
      C_BRANCH:  begin use1 = 1'b1; use2 = 1'b1; fixed_cost = CNT_W'(br_taken); end
      C_ALU_IMM, C_LOAD, C_STORE, C_CSR_REG: use1 = 1'b1;
      C_JALR:    begin use1 = 1'b1; fixed_cost = CNT_W'(1); end
      C_JAL:     fixed_cost = CNT_W'(1);
      default: ;
    endcase
  end

  wire hit = rec_vld && ((use1 && src1 == rec_reg) || (use2 && src2 == rec_reg));
  wire late = (issue_cls == C_LOAD || issue_cls == C_MUL) && dst != '0;

  assign stall_cnt = issue_vld ? fixed_cost + CNT_W'(hit) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_vld <= 1'b0;
      rec_reg <= '0;
    end else if (issue_vld) begin
      rec_vld <= late;
      rec_reg <= late ? dst : '0;
    end
  end

  assert_x0_never_recorded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld |-> rec_reg != '0);

  assert_late_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && (issue_cls == C_LOAD || issue_cls == C_MUL) && dst != '0)
      |=> (rec_vld && rec_reg == $past(dst)));

  assert_other_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && issue_cls != C_LOAD && issue_cls != C_MUL) |=> !rec_vld);

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> ($stable(rec_vld) && $stable(rec_reg)));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |-> stall_cnt == '0);

  assert_div_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && issue_cls == C_DIV) |-> stall_cnt >= CNT_W'(DIV_COST));

  assert_no_source_cost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && issue_cls >= 4'd10) |-> stall_cnt == '0);

endmodule

// File: tb/sim_issue_penalty_calc.sv
module sim_issue_penalty_calc;
  localparam int REG_W = 5;
  localparam int DIV_COST = 18;
  localparam int CNT_W = $clog2(DIV_COST + 3);

  logic clk = 0, rst_n = 0;
  logic issue_vld = 0, br_taken = 0;
  logic [3:0] issue_cls = 0;
  logic [REG_W-1:0] src1 = 0, src2 = 0, dst = 0;
  logic [CNT_W-1:0] stall_cnt;
  logic rec_vld;
  logic [REG_W-1:0] rec_reg;

  issue_penalty_calc #(.REG_W(REG_W), .DIV_COST(DIV_COST)) u0 (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_cls(issue_cls),
    .src1(src1), .src2(src2), .dst(dst), .br_taken(br_taken),
    .stall_cnt(stall_cnt), .rec_vld(rec_vld), .rec_reg(rec_reg));

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit m_v = 0;
  int m_r = 0;
  int q_stall[$];
  int q_rv[$];
  int q_rr[$];
  string q_tag[$];

  function automatic int model_cost(int c, int a, int b, bit tk);
    bit u1 = 0, u2 = 0;
    int fx = 0;
    case (c)
      0, 1: begin u1 = 1; u2 = 1; end
      2: begin u1 = 1; u2 = 1; fx = DIV_COST; end
      6: begin u1 = 1; u2 = 1; fx = tk ? 1 : 0; end
      3, 4, 5, 9: u1 = 1;
      8: begin u1 = 1; fx = 1; end
      7: fx = 1;
      default: ;
    endcase
    return fx + ((m_v && ((u1 && a == m_r) || (u2 && b == m_r))) ? 1 : 0);
  endfunction

  task automatic push(int s, string tag);
    q_stall.push_back(s);
    q_rv.push_back(m_v);
    q_rr.push_back(m_r);
    q_tag.push_back(tag);
  endtask

  task automatic issue(int c, int a, int b, int d, bit tk, string tag);
    @(negedge clk);
    issue_vld = 1; issue_cls = 4'(c); src1 = REG_W'(a); src2 = REG_W'(b);
    dst = REG_W'(d); br_taken = tk;
    push(model_cost(c, a, b, tk), tag);
    if ((c == 4 || c == 1) && d != 0) begin m_v = 1; m_r = d; end
    else begin m_v = 0; m_r = 0; end
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    issue_vld = 0; issue_cls = 4'd0; src1 = '0; src2 = '0; dst = '0; br_taken = 0;
    push(0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #5;
      if (q_stall.size() > 0) begin
        int es, ev, er;
        string t;
        es = q_stall.pop_front(); ev = q_rv.pop_front();
        er = q_rr.pop_front(); t = q_tag.pop_front();
        n_run++;
        if (int'(stall_cnt) != es) begin
          n_fail++;
          $display("FAIL %s stall_cnt actual %0d expected %0d", t, stall_cnt, es);
        end
        n_run++;
        if (int'(rec_vld) != ev || (ev == 1 && int'(rec_reg) != er)) begin
          n_fail++;
          $display("FAIL %s record actual %0d/%0d expected %0d/%0d", t, rec_vld, rec_reg, ev, er);
        end
      end
    end
  end

  initial begin : driver
    #35 rst_n = 1;
    idle("R9 reset empty, idle zero");
    issue(4, 1, 2, 5, 0, "R1 load fill");
    issue(0, 1, 5, 2, 0, "R3 rs2 interlock");
    issue(0, 5, 5, 2, 0, "R1 record cleared");
    issue(1, 3, 3, 7, 0, "R1 mul fill");
    issue(6, 7, 1, 0, 1, "R5 taken plus interlock R3");
    issue(4, 1, 1, 0, 0, "R2 load to x0");
    issue(0, 0, 0, 3, 0, "R2 no x0 interlock");
    issue(4, 1, 1, 3, 0, "R1 load fill");
    issue(5, 1, 3, 0, 0, "R4 store rs2 ignored");
    issue(4, 1, 1, 3, 0, "R1 load fill");
    issue(3, 3, 0, 4, 0, "R4 imm rs1 interlock");
    issue(1, 2, 2, 9, 0, "R1 mul fill");
    issue(2, 1, 9, 4, 0, "R7 div plus interlock");
    issue(2, 1, 9, 4, 0, "R7 div alone");
    issue(7, 0, 0, 1, 0, "R6 jal");
    issue(4, 2, 2, 4, 0, "R1 load fill");
    issue(8, 4, 0, 1, 0, "R6 jalr plus interlock");
    issue(4, 2, 2, 6, 0, "R1 load fill");
    issue(11, 6, 6, 1, 0, "R8 lui no compare");
    issue(4, 2, 2, 6, 0, "R1 load fill");
    issue(10, 6, 6, 1, 0, "R8 csr imm no compare");
    issue(4, 2, 2, 6, 0, "R1 load fill");
    issue(9, 6, 1, 1, 0, "R4 csr reg interlock");
    issue(6, 1, 2, 0, 0, "R5 not taken");
    issue(6, 1, 2, 0, 1, "R5 taken no hazard");
    issue(4, 2, 2, 8, 0, "R1 load fill");
    idle("R9 idle holds");
    idle("R9 idle holds");
    issue(3, 8, 0, 1, 0, "R9 held record interlock");
    issue(1, 1, 1, 10, 0, "R1 mul fill");
    issue(12, 10, 10, 1, 0, "R8 auipc");
    issue(1, 1, 1, 10, 0, "R1 mul fill");
    issue(13, 10, 10, 0, 0, "R8 fence");
    issue(1, 1, 1, 10, 0, "R1 mul fill");
    issue(15, 10, 10, 10, 0, "R8 unused code clears");
    idle("R1 unused code emptied record");
    wait (q_stall.size() == 0);
    @(negedge clk); #8;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule